// File: doc/BRIEF.md
# 8b/10b Code Group Decoder

This block turns one 10-bit line code group per clock back into the byte it carries. It is meant to sit right after a deserializer that has already found word alignment. Each rising edge samples the group on `code_in`. From that edge until the next one, the block presents four results: the decoded byte, a flag that marks the twelve control symbols, the running disparity after the group, and an error indication.

The 10-bit group is split into a 6-bit sub-block and a 4-bit sub-block. Each is decoded on its own table, and a single shared disparity tracker checks the pair. The decoder keeps no history other than the running disparity. It does not try to recover from bad groups: it only reports them and goes on.

The `ERR_EN` parameter chooses whether the error output is built. When it is 0, `err_out` is held low.

Top module: `dec8b10b`

## Requirements
- R1: Bit layout. `code_in[9:4]` is the 6-bit sub-block written abcdei, with a at bit 9. `code_in[3:0]` is the 4-bit sub-block written fghj, with f at bit 3. `data_out[4:0]` carries the 5-bit value decoded from the 6-bit sub-block, and `data_out[7:5]` carries the 3-bit value decoded from the 4-bit sub-block. The result of a group sampled at a rising edge appears after that edge and holds until the next edge.
- R2: The positive-disparity and negative-disparity forms of any sub-block decode to the same value. The primary codes of the 3-bit value 7 (1110/0001) and the alternate codes (0111/1000) both decode to 7.
- R3: `ctrl_out` is high in two cases. The first is a 6-bit sub-block of 001111 or 110000 (value 28). The second is a 6-bit sub-block decoding to 23, 27, 29 or 30 followed by an alternate code 0111 or 1000. After 110000, any 4-bit code holding two ones is complemented before it is decoded.
- R4: `rd_out` is the running disparity, where 1 means positive. The 6-bit sub-block is applied first: more than three ones sets it, fewer than three clears it, and exactly three leaves it unchanged. The 4-bit sub-block is applied next in the same way, with two as the threshold.
- R5: `err_out` is high for a group whose 6-bit or 4-bit sub-block is not a code of the table. A sub-block that is not in the table decodes to zero in its field of `data_out`.
- R6: `err_out` is high for a disparity clash in any of these cases:
  - an unbalanced sub-block has the same sign as the running disparity entering it;
  - 111000 or 1100 arrives while the disparity is positive;
  - 000111 or 0011 arrives while the disparity is negative.
- R7: Asserting `rst` clears `data_out`, `ctrl_out`, `err_out` and `rd_out` (negative) at once, without waiting for a clock edge.
- R8: A stream made by a conforming encoder reproduces every one of the 256 data bytes and all 12 control symbols, with `ctrl_out` matching the symbol kind and `err_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the group is sampled on its rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| code_in | input | 10 | Received code group, abcdei in bits 9:4, fghj in bits 3:0 |
| data_out | output | 8 | Decoded byte, registered |
| ctrl_out | output | 1 | High when the last group was a control symbol |
| rd_out | output | 1 | Running disparity after the last group, 1 = positive |
| err_out | output | 1 | Code or disparity violation in the last group |

## Verification
On every cycle, the assertions check three things. First, the disparity responds to the weight of the 4-bit sub-block and stays put for a fully neutral group. Second, a set control flag only comes with one of the twelve symbol values. Third, sub-blocks of impossible weight and unbalanced sub-blocks that clash with the current disparity raise the error. Other behaviour can only be shown by the bench's scenarios. This covers the exact byte value for every table entry in both disparity forms and both sevens, the complemented 4-bit decode after 110000, and the full data and control round trip. It also covers a reset arriving mid-stream, and clashes produced by the balanced 111000/000111 and 1100/0011 codes.

// File: rtl/dec8b10b_pkg.sv
package dec8b10b_pkg;
    localparam int SUB6_W = 6;
    localparam int SUB4_W = 4;
    localparam int X_W    = 5;
    localparam int Y_W    = 3;
    localparam int CG_W   = SUB6_W + SUB4_W;
    localparam int BYTE_W = X_W + Y_W;
    localparam int HALF6  = SUB6_W / 2;
    localparam int HALF4  = SUB4_W / 2;

    typedef struct packed {
        logic [BYTE_W-1:0] dat;
        logic              ctrl;
        logic              rd;
        logic              err;
    } dec_out_t;
endpackage

// File: rtl/sub6_dec.sv
module sub6_dec
    import dec8b10b_pkg::*;
(
    input  logic [SUB6_W-1:0] s6,
    output logic [X_W-1:0]    x,
    output logic              ok,
    output logic              k28,
    output logic              flip
);
    always_comb begin
        x    = '0;
        ok   = 1'b1;
        k28  = 1'b0;
        flip = (s6 == 6'b110000);
        case (s6)
            6'b100111, 6'b011000: x = 5'd0;
            6'b011101, 6'b100010: x = 5'd1;
            6'b101101, 6'b010010: x = 5'd2;
            6'b110001:            x = 5'd3;
            6'b110101, 6'b001010: x = 5'd4;
            6'b101001:            x = 5'd5;
            6'b011001:            x = 5'd6;
            6'b111000, 6'b000111: x = 5'd7;
            6'b111001, 6'b000110: x = 5'd8;
            6'b100101:            x = 5'd9;
            6'b010101:            x = 5'd10;
            6'b110100:            x = 5'd11;
            6'b001101:            x = 5'd12;
            6'b101100:            x = 5'd13;
            6'b011100:            x = 5'd14;
            6'b010111, 6'b101000: x = 5'd15;
            6'b011011, 6'b100100: x = 5'd16;
            6'b100011:            x = 5'd17;
            6'b010011:            x = 5'd18;
            6'b110010:            x = 5'd19;
            6'b001011:            x = 5'd20;
            6'b101010:            x = 5'd21;
            6'b011010:            x = 5'd22;
            6'b111010, 6'b000101: x = 5'd23;
            6'b110011, 6'b001100: x = 5'd24;
            6'b100110:            x = 5'd25;
            6'b010110:            x = 5'd26;
            6'b110110, 6'b001001: x = 5'd27;
            6'b001110:            x = 5'd28;
            6'b101110, 6'b010001: x = 5'd29;
            6'b011110, 6'b100001: x = 5'd30;
            6'b101011, 6'b010100: x = 5'd31;
            6'b001111, 6'b110000: begin
                x   = 5'd28;
                k28 = 1'b1;
            end
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/sub4_dec.sv
module sub4_dec
    import dec8b10b_pkg::*;
(
    input  logic [SUB4_W-1:0] s4,
    input  logic              flip,
    output logic [Y_W-1:0]    y,
    output logic              ok,
    output logic              alt
);
    logic [SUB4_W-1:0] t;

    always_comb begin
        t   = (flip && ($countones(s4) == HALF4)) ? ~s4 : s4;
        y   = '0;
        ok  = 1'b1;
        alt = 1'b0;
        case (t)
            4'b1011, 4'b0100: y = 3'd0;
            4'b1001:          y = 3'd1;
            4'b0101:          y = 3'd2;
            4'b1100, 4'b0011: y = 3'd3;
            4'b1101, 4'b0010: y = 3'd4;
            4'b1010:          y = 3'd5;
            4'b0110:          y = 3'd6;
            4'b1110, 4'b0001: y = 3'd7;
            4'b0111, 4'b1000: begin
                y   = 3'd7;
                alt = 1'b1;
            end
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/disp_track.sv
module disp_track
    import dec8b10b_pkg::*;
(
    input  logic              rd_in,
    input  logic [SUB6_W-1:0] s6,
    input  logic [SUB4_W-1:0] s4,
    output logic              rd_out,
    output logic              bad
);
    int   n6;
    int   n4;
    logic rd_mid;

    always_comb begin
        n6     = $countones(s6);
        n4     = $countones(s4);
        bad    = 1'b0;
        rd_mid = rd_in;
        if (n6 > HALF6) begin
            bad    = rd_in;
            rd_mid = 1'b1;
        end else if (n6 < HALF6) begin
            bad    = !rd_in;
            rd_mid = 1'b0;
        end else if (s6 == 6'b111000) begin
            bad = rd_in;
        end else if (s6 == 6'b000111) begin
            bad = !rd_in;
        end

        rd_out = rd_mid;
        if (n4 > HALF4) begin
            bad    = bad | rd_mid;
            rd_out = 1'b1;
        end else if (n4 < HALF4) begin
            bad    = bad | !rd_mid;
            rd_out = 1'b0;
        end else if (s4 == 4'b1100) begin
            bad = bad | rd_mid;
        end else if (s4 == 4'b0011) begin
            bad = bad | !rd_mid;
        end
    end
endmodule

// File: rtl/dec8b10b.sv
module dec8b10b
    import dec8b10b_pkg::*;
#(
    parameter bit ERR_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CG_W-1:0]   code_in,
    output logic [BYTE_W-1:0] data_out,
    output logic              ctrl_out,
    output logic              rd_out,
    output logic              err_out
);
    dec_out_t          st_d, st_q;
    logic [X_W-1:0]    x5;
    logic [Y_W-1:0]    y3;
    logic              ok6, ok4, k28, flip, alt;
    logic              rd_nx, dbad, err_raw, kx;

    sub6_dec u_s6 (
        .s6   (code_in[CG_W-1:SUB4_W]),
        .x    (x5),
        .ok   (ok6),
        .k28  (k28),
        .flip (flip)
    );

    sub4_dec u_s4 (
        .s4   (code_in[SUB4_W-1:0]),
        .flip (flip),
        .y    (y3),
        .ok   (ok4),
        .alt  (alt)
    );

    disp_track u_rd (
        .rd_in  (st_q.rd),
        .s6     (code_in[CG_W-1:SUB4_W]),
        .s4     (code_in[SUB4_W-1:0]),
        .rd_out (rd_nx),
        .bad    (dbad)
    );

    generate
        if (ERR_EN) begin : g_err
            assign err_raw = !ok6 || !ok4 || dbad;
        end else begin : g_noerr
            assign err_raw = 1'b0;
        end
    endgenerate

    always_comb begin
        kx = alt && ok6 &&
             ((x5 == 5'd23) || (x5 == 5'd27) || (x5 == 5'd29) || (x5 == 5'd30));
        st_d.dat  = {y3, x5};
        st_d.ctrl = k28 || kx;
        st_d.rd   = rd_nx;
        st_d.err  = err_raw;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data_out = st_q.dat;
    assign ctrl_out = st_q.ctrl;
    assign rd_out   = st_q.rd;
    assign err_out  = st_q.err;
endmodule

// File: rtl/dec8b10b_chk.sv
module dec8b10b_chk #(
    parameter bit ERR_EN = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic [9:0] code_in,
    input logic [7:0] data_out,
    input logic       ctrl_out,
    input logic       rd_out,
    input logic       err_out
);
    logic neutral;
    assign neutral = ($countones(code_in[9:4]) == 3) && ($countones(code_in[3:0]) == 2) &&
                     (code_in[9:4] != 6'b111000) && (code_in[9:4] != 6'b000111) &&
                     (code_in[3:0] != 4'b1100) && (code_in[3:0] != 4'b0011);

    AST_CTRL_SYMBOL: assert property (@(posedge clk) disable iff (rst) ctrl_out |-> (data_out[4:0] inside {5'd23, 5'd27, 5'd28, 5'd29, 5'd30})); // R3
    AST_CTRL_SEVEN: assert property (@(posedge clk) disable iff (rst) (ctrl_out && data_out[4:0] != 5'd28) |-> (data_out[7:5] == 3'd7)); // R3
    AST_RD_UP: assert property (@(posedge clk) disable iff (rst) ($countones(code_in[3:0]) > 2) |=> rd_out); // R4
    AST_RD_DOWN: assert property (@(posedge clk) disable iff (rst) ($countones(code_in[3:0]) < 2) |=> !rd_out); // R4
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) neutral |=> $stable(rd_out)); // R4
    AST_BAD_WEIGHT: assert property (@(posedge clk) disable iff (rst || !ERR_EN) (($countones(code_in[9:4]) inside {0, 1, 5, 6}) || ($countones(code_in[3:0]) inside {0, 4})) |=> err_out); // R5
    AST_DISP_CLASH: assert property (@(posedge clk) disable iff (rst || !ERR_EN) (($countones(code_in[9:4]) > 3) && rd_out) |=> err_out); // R6
    AST_RST_CLEAR: assert property (@(negedge clk) rst |-> (data_out == 8'd0 && !ctrl_out && !rd_out && !err_out)); // R7
endmodule

bind dec8b10b dec8b10b_chk #(.ERR_EN(ERR_EN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .code_in  (code_in),
    .data_out (data_out),
    .ctrl_out (ctrl_out),
    .rd_out   (rd_out),
    .err_out  (err_out)
);

// File: tb/dec8b10b_test.sv
module dec8b10b_test;
    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic [9:0] code_in = 10'b110001_1010;
    logic [7:0] data_out;
    logic       ctrl_out, rd_out, err_out;

    dec8b10b uut (
        .clk(clk), .rst(rst), .code_in(code_in),
        .data_out(data_out), .ctrl_out(ctrl_out), .rd_out(rd_out), .err_out(err_out)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [7:0] d;
        logic       c;
        logic       r;
        logic       e;
        bit         rt;
        logic [7:0] od;
        bit         ok;
    } exp_t;

    exp_t     q[$];
    int       n_chk = 0;
    int       n_bad = 0;
    bit       m_rd = 1'b0;
    bit       enc_rd = 1'b0;
    bit [5:0] m6 [32];
    bit [3:0] m4 [8];
    bit [7:0] ksym [12];

    function automatic bit [5:0] p6(input int x);
        return ($countones(m6[x]) != 3 || x == 7) ? ~m6[x] : m6[x];
    endfunction

    function automatic bit [3:0] p4(input int y);
        return ($countones(m4[y]) != 2 || y == 3) ? ~m4[y] : m4[y];
    endfunction

    function automatic bit [9:0] enc(input bit [7:0] b, input bit k, inout bit rd);
        int x = int'(b[4:0]);
        int y = int'(b[7:5]);
        bit [5:0] c6;
        bit [3:0] c4;
        bit rdm, use_alt;
        if (k && x == 28) c6 = rd ? 6'b110000 : 6'b001111;
        else              c6 = rd ? p6(x) : m6[x];
        rdm = ($countones(c6) > 3) ? 1'b1 : ($countones(c6) < 3) ? 1'b0 : rd;
        use_alt = (y == 7) && (k || (!rdm && (x == 17 || x == 18 || x == 20)) ||
                                (rdm && (x == 11 || x == 13 || x == 14)));
        if (use_alt) c4 = rdm ? 4'b1000 : 4'b0111;
        else         c4 = rdm ? p4(y) : m4[y];
        if (k && x == 28 && $countones(c4) == 2 && y != 3 && !rdm) c4 = ~c4;
        rd = ($countones(c4) > 2) ? 1'b1 : ($countones(c4) < 2) ? 1'b0 : rdm;
        return {c6, c4};
    endfunction

    task automatic model(input bit [9:0] c, output exp_t e);
        bit [5:0] s6 = c[9:4];
        bit [3:0] s4 = c[3:0];
        bit [3:0] t;
        int x = 0, y = 0;
        bit ok6 = 0, ok4 = 0, k28 = 0, alt = 0, bad = 0, rdm;
        if (s6 == 6'b001111 || s6 == 6'b110000) begin x = 28; ok6 = 1; k28 = 1; end
        else for (int i = 0; i < 32; i++)
            if (s6 == m6[i] || s6 == p6(i)) begin x = i; ok6 = 1; end
        t = (s6 == 6'b110000 && $countones(s4) == 2) ? ~s4 : s4;
        for (int i = 0; i < 8; i++)
            if (t == m4[i] || t == p4(i)) begin y = i; ok4 = 1; end
        if (t == 4'b0111 || t == 4'b1000) begin y = 7; ok4 = 1; alt = 1; end
        rdm = m_rd;
        if ($countones(s6) > 3)      begin if (m_rd) bad = 1; rdm = 1; end
        else if ($countones(s6) < 3) begin if (!m_rd) bad = 1; rdm = 0; end
        else if (s6 == 6'b111000 && m_rd) bad = 1;
        else if (s6 == 6'b000111 && !m_rd) bad = 1;
        m_rd = rdm;
        if ($countones(s4) > 2)      begin if (rdm) bad = 1; m_rd = 1; end
        else if ($countones(s4) < 2) begin if (!rdm) bad = 1; m_rd = 0; end
        else if (s4 == 4'b1100 && rdm) bad = 1;
        else if (s4 == 4'b0011 && !rdm) bad = 1;
        e.d  = {y[2:0], x[4:0]};
        e.c  = k28 || (alt && ok6 && (x == 23 || x == 27 || x == 29 || x == 30));
        e.r  = m_rd;
        e.e  = !ok6 || !ok4 || bad;
        e.rt = 0; e.od = 0; e.ok = 0;
    endtask

    task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic check_pending();
        exp_t e;
        if (q.size() == 0) return;
        e = q.pop_front();
        chk(data_out === e.d, "R1 R2 R5 data", data_out, e.d);
        chk(ctrl_out === e.c, "R3 ctrl", ctrl_out, e.c);
        chk(rd_out === e.r, "R4 disparity", rd_out, e.r);
        chk(err_out === e.e, "R5 R6 error", err_out, e.e);
        if (e.rt) begin
            chk(data_out === e.od, "R8 round-trip byte", data_out, e.od);
            chk(ctrl_out === e.ok, "R8 round-trip kind", ctrl_out, e.ok);
            chk(err_out === 1'b0, "R8 round-trip error", err_out, 0);
        end
    endtask

    task automatic step(input bit [9:0] c, input bit rt, input bit [7:0] od, input bit k);
        exp_t e;
        @(negedge clk);
        check_pending();
        code_in = c;
        model(c, e);
        e.rt = rt; e.od = od; e.ok = k;
        q.push_back(e);
    endtask

    task automatic send(input bit [7:0] b, input bit k);
        step(enc(b, k, enc_rd), 1'b1, b, k);
    endtask

    task automatic release_rst();
        exp_t e;
        @(negedge clk);
        rst = 1'b0;
        m_rd = 1'b0;
        enc_rd = 1'b0;
        q.delete();
        model(code_in, e);
        q.push_back(e);
    endtask

    task automatic check_reset_state();
        chk(data_out === 8'd0, "R7 reset data", data_out, 0);
        chk(ctrl_out === 1'b0, "R7 reset ctrl", ctrl_out, 0);
        chk(rd_out === 1'b0, "R7 reset disparity", rd_out, 0);
        chk(err_out === 1'b0, "R7 reset error", err_out, 0);
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit tmp;
        m6 = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001, 6'b011001, 6'b111000,
               6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100, 6'b011100, 6'b010111,
               6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
               6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
        m4 = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
        ksym = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};

        #1 rst = 1'b1;
        #1 check_reset_state();
        release_rst();

        // R8: every data byte then every control symbol, forward order
        for (int i = 0; i < 256; i++) send(8'(i), 1'b0);
        for (int i = 0; i < 12; i++) send(ksym[i], 1'b1);
        // R2 R8: reverse order gives other disparity forms and sevens
        for (int i = 255; i >= 0; i--) send(8'(i), 1'b0);
        for (int i = 11; i >= 0; i--) send(ksym[i], 1'b1);
        // R3: control symbols from both disparity states
        for (int i = 0; i < 12; i++) begin
            send(8'h00, 1'b0);
            send(ksym[i], 1'b1);
            send(ksym[i], 1'b1);
        end

        // R5: groups outside the table
        step(10'b111111_1011, 1'b0, 8'h00, 1'b0);
        step(10'b110001_1111, 1'b0, 8'h00, 1'b0);
        step(10'b110011_0000, 1'b0, 8'h00, 1'b0);
        step(10'b011001_0111, 1'b0, 8'h00, 1'b0);
        // R6: wrong-sign forms
        tmp = !m_rd;
        step(enc(8'h00, 1'b0, tmp), 1'b0, 8'h00, 1'b0);
        tmp = !m_rd;
        step(enc(8'hB5, 1'b0, tmp), 1'b0, 8'h00, 1'b0);
        tmp = m_rd;
        step(m_rd ? 10'b111000_1100 : 10'b000111_0011, 1'b0, 8'h00, 1'b0);
        enc_rd = m_rd;
        for (int i = 0; i < 8; i++) send(8'(i * 37), 1'b0);

        // R7: reset in the middle of a stream
        @(negedge clk);
        check_pending();
        #2 rst = 1'b1;
        #1 check_reset_state();
        release_rst();
        for (int i = 0; i < 12; i++) send(ksym[i], 1'b1);
        for (int i = 0; i < 16; i++) send(8'(i * 17 + 3), 1'b0);
        step(10'b110001_1010, 1'b0, 8'h00, 1'b0);
        @(negedge clk);
        check_pending();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule